// File: doc/BRIEF.md
# Buffered Power-of-Two PWM Generator

This block produces a pulse-width modulated waveform from an 8-bit up counter whose period is a power of two: 64, 128 or 256 counts. An output flip-flop changes state twice in every period. It inverts once when the counter reaches the compare value and once when the counter wraps. The compare value therefore sets the pulse width, and the period field sets the repetition rate. A period interrupt pulses at each wrap.

The counter advances on one of four count sources. Three are single-cycle prescaled ticks supplied from outside the block: every cycle, every 4th cycle and every 16th cycle. The fourth is an asynchronous external count input. That input is synchronised and edge-detected inside the block. The compare value can be written straight into the active register. It can also be written into a shadow buffer, which is copied into the active register only at the wrap, so a new width never tears a period in progress. Software can preset or clear the flip-flop, and a separate enable can freeze its toggling.

Top module: `pow2_pwm`

## Requirements
- R1: `src_sel` picks the count source: 00 counts on `tick_div1`, 01 on `tick_div4`, 10 on `tick_div16`, 11 on rising edges of `ext_cnt_in`. Ticks from the unselected sources have no effect.
- R2: `period_sel` 01, 10 and 11 give periods of 64, 128 and 256 counts. `period_irq` is high for exactly one clock cycle at each wrap, in the cycle after the edge where the counter returns to zero.
- R3: `period_sel` 00 holds the counter, and while it is selected `period_irq` never pulses.
- R4: `pwm_out` inverts on the edge where the counter wraps and again on the edge where the counter reaches the active compare value. After a wrap, the next inversion therefore comes exactly `compare` counts later.
- R5: With `buf_en` low, a compare write updates the active value on the next clock edge, and it governs the match in the period already running.
- R6: With `buf_en` high, a compare write goes to the shadow buffer, and the buffer is copied into the active value at the next wrap. A write on the same edge as a wrap reaches the active value at the wrap after that one.
- R7: While `run` is low the counter is held at zero and `period_irq` stays low. When `run` rises, the count restarts from zero.
- R8: While `ff_inv_en` is low, `pwm_out` does not invert on a match or a wrap, but `period_irq` keeps pulsing.
- R9: A pulse on `ff_wr` loads `ff_wdata` into `pwm_out` on the next edge. This write takes precedence over a match or wrap inversion on the same edge.
- R10: `ext_cnt_in` passes through a two-stage synchroniser. Each rising edge advances the counter by exactly one, and holding the input high adds no further counts.
- R11: After reset, `pwm_out` and `period_irq` are low and the active compare value is zero, so only the wraps invert the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_div1 | input | 1 | Count tick at the undivided rate |
| tick_div4 | input | 1 | Count tick at one quarter rate |
| tick_div16 | input | 1 | Count tick at one sixteenth rate |
| ext_cnt_in | input | 1 | Asynchronous external count input |
| src_sel | input | 2 | Count source select |
| run | input | 1 | Counting enable; low clears the counter |
| period_sel | input | 2 | Period code (00 hold, 01/10/11 for 64/128/256) |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | Compare write data |
| buf_en | input | 1 | Route compare writes through the shadow buffer |
| ff_wr | input | 1 | Software load of the output flip-flop |
| ff_wdata | input | 1 | Value loaded by `ff_wr` |
| ff_inv_en | input | 1 | Enable for match and wrap inversions |
| pwm_out | output | 1 | Output flip-flop level |
| period_irq | output | 1 | One-cycle pulse at each wrap |

## Verification
Two pairs of functions can land on the same clock edge. The wrap can coincide with a buffered compare write, and the wrap inversion can coincide with a software load of the flip-flop. The bench counts cycles from a visible interrupt so that it can place the write strobe on exactly the edge where the next wrap happens. For the flip-flop case, it loads the level the output already holds, so a lost override shows up as an inversion. For the buffer case, it judges the outcome by the pulse widths of the two following periods: the first must still show the older buffered value, and the second the value written at the wrap.

// File: rtl/pow2_pwm_pkg.sv
package pow2_pwm_pkg;

   typedef enum logic [1:0] {
      SRC_DIV1  = 2'b00,
      SRC_DIV4  = 2'b01,
      SRC_DIV16 = 2'b10,
      SRC_EXT   = 2'b11
   } src_e;

   typedef enum logic [1:0] {
      PER_HOLD  = 2'b00,
      PER_SHORT = 2'b01,
      PER_MID   = 2'b10,
      PER_FULL  = 2'b11
   } per_e;

endpackage

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel
   import pow2_pwm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_div1,
   input  logic       tick_div4,
   input  logic       tick_div16,
   input  logic       ext_in,
   input  logic [1:0] src_sel,
   output logic       tick
);

   localparam int TOP = SYNC_STAGES - 1;

   logic [TOP:0] sync_q;
   logic         last_q;
   logic         ext_edge;
   src_e         sel;

   // synchroniser chain, one register per stage
   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= ext_in;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[TOP];
   end

   assign ext_edge = sync_q[TOP] & ~last_q;
   assign sel      = src_e'(src_sel);

   always_comb begin
      unique case (sel)
         SRC_DIV1:  tick = tick_div1;
         SRC_DIV4:  tick = tick_div4;
         SRC_DIV16: tick = tick_div16;
         SRC_EXT:   tick = ext_edge;
      endcase
   end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
   import pow2_pwm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic [1:0]       period_sel,
   input  logic [CNT_W-1:0] cmp_val,
   output logic             wrap_evt,
   output logic             match_evt
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] last_val;
   logic             adv;
   logic             at_end;

   // highest counter value of the selected period: 2^(CNT_W-3+code) - 1
   function automatic logic [CNT_W-1:0] period_last(input logic [1:0] code);
      logic [CNT_W:0] pow;
      for (int k = 0; k <= CNT_W; k++)
         pow[k] = (k == CNT_W - 3 + int'(code));
      return pow[CNT_W-1:0] - ONE;
   endfunction

   always_comb begin
      last_val  = period_last(period_sel);
      adv       = run && (per_e'(period_sel) != PER_HOLD) && tick;
      at_end    = (cnt_q >= last_val);
      cnt_nxt   = cnt_q + ONE;
      wrap_evt  = adv && at_end;
      match_evt = adv && !at_end && (cnt_nxt == cmp_val);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!run)     cnt_q <= '0;
      else if (wrap_evt) cnt_q <= '0;
      else if (adv)      cnt_q <= cnt_nxt;
   end

endmodule

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             buf_en,
   input  logic             reload,
   output logic [CNT_W-1:0] cmp_val
);

   logic [CNT_W-1:0] shadow_q;
   logic [CNT_W-1:0] active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  shadow_q <= '0;
      else if (wr) shadow_q <= wdata;
   end

   // a wrap copies the shadow as it stood before any write on that edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                active_q <= '0;
      else if (wr && !buf_en)    active_q <= wdata;
      else if (reload && buf_en) active_q <= shadow_q;
   end

   assign cmp_val = active_q;

endmodule

// File: rtl/pwm_flop.sv
module pwm_flop (
   input  logic clk,
   input  logic rst_n,
   input  logic toggle,
   input  logic inv_en,
   input  logic sw_wr,
   input  logic sw_data,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q <= 1'b0;
      else if (sw_wr)            q <= sw_data;
      else if (toggle && inv_en) q <= ~q;
   end

endmodule

// File: rtl/pow2_pwm.sv
module pow2_pwm #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_div1,
   input  logic             tick_div4,
   input  logic             tick_div16,
   input  logic             ext_cnt_in,
   input  logic [1:0]       src_sel,
   input  logic             run,
   input  logic [1:0]       period_sel,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             buf_en,
   input  logic             ff_wr,
   input  logic             ff_wdata,
   input  logic             ff_inv_en,
   output logic             pwm_out,
   output logic             period_irq
);

   initial begin : g_param_check
      if (CNT_W < 3)
         $fatal(1, "pow2_pwm: CNT_W must be at least 3");
      if (SYNC_STAGES < 2)
         $fatal(1, "pow2_pwm: SYNC_STAGES must be at least 2");
   end

   logic             tick;
   logic             wrap_evt;
   logic             match_evt;
   logic [CNT_W-1:0] cmp_val;
   logic             irq_q;

   pwm_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_div1  (tick_div1),
      .tick_div4  (tick_div4),
      .tick_div16 (tick_div16),
      .ext_in     (ext_cnt_in),
      .src_sel    (src_sel),
      .tick       (tick)
   );

   pwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .run        (run),
      .period_sel (period_sel),
      .cmp_val    (cmp_val),
      .wrap_evt   (wrap_evt),
      .match_evt  (match_evt)
   );

   pwm_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cmp_wr),
      .wdata   (cmp_wdata),
      .buf_en  (buf_en),
      .reload  (wrap_evt),
      .cmp_val (cmp_val)
   );

   pwm_flop u_ff (
      .clk     (clk),
      .rst_n   (rst_n),
      .toggle  (wrap_evt | match_evt),
      .inv_en  (ff_inv_en),
      .sw_wr   (ff_wr),
      .sw_data (ff_wdata),
      .q       (pwm_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= wrap_evt;
   end

   assign period_irq = irq_q;

endmodule

// File: rtl/pow2_pwm_chk.sv
module pow2_pwm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       run,
   input logic [1:0] period_sel,
   input logic       ff_wr,
   input logic       ff_wdata,
   input logic       ff_inv_en,
   input logic       pwm_out,
   input logic       period_irq
);

   // R11: outputs are low while reset is applied
   a_r11_reset_low: assert property (@(posedge clk)
      !rst_n |=> (!pwm_out && !period_irq));

   // R2: the period interrupt lasts a single cycle
   a_r2_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      period_irq |=> !period_irq);

   // R3: hold code produces no interrupt
   a_r3_hold_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (period_sel == 2'b00) |=> !period_irq);

   // R7: stopped counter produces no interrupt
   a_r7_stop_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !period_irq);

   // R8: disabled inversion freezes the level
   a_r8_inv_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!ff_inv_en && !ff_wr) |=> $stable(pwm_out));

   // R9: software load wins on the following edge
   a_r9_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
      ff_wr |=> (pwm_out == $past(ff_wdata)));

   // R4: a wrap inverts the output when inversion is enabled
   a_r4_wrap_inverts: assert property (@(posedge clk) disable iff (!rst_n)
      (period_irq && $past(ff_inv_en) && !$past(ff_wr)) |-> (pwm_out != $past(pwm_out)));

endmodule

bind pow2_pwm pow2_pwm_chk i_pow2_pwm_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run),
   .period_sel (period_sel),
   .ff_wr      (ff_wr),
   .ff_wdata   (ff_wdata),
   .ff_inv_en  (ff_inv_en),
   .pwm_out    (pwm_out),
   .period_irq (period_irq)
);

// File: tb/test_pow2_pwm.sv
module test_pow2_pwm;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_div1 = 1'b1;
   logic       tick_div4 = 1'b0;
   logic       tick_div16 = 1'b0;
   logic       ext_cnt_in = 1'b0;
   logic [1:0] src_sel = 2'b00;
   logic       run = 1'b0;
   logic [1:0] period_sel = 2'b01;
   logic       cmp_wr = 1'b0;
   logic [7:0] cmp_wdata = 8'd0;
   logic       buf_en = 1'b0;
   logic       ff_wr = 1'b0;
   logic       ff_wdata = 1'b0;
   logic       ff_inv_en = 1'b1;
   logic       pwm_out;
   logic       period_irq;

   int errors = 0;
   int checks = 0;
   int phase  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   always @(negedge clk) begin
      phase++;
      tick_div4  = (phase % 4 == 0);
      tick_div16 = (phase % 16 == 0);
   end

   pow2_pwm i_pow2_pwm (
      .clk(clk), .rst_n(rst_n), .tick_div1(tick_div1), .tick_div4(tick_div4),
      .tick_div16(tick_div16), .ext_cnt_in(ext_cnt_in), .src_sel(src_sel),
      .run(run), .period_sel(period_sel), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
      .buf_en(buf_en), .ff_wr(ff_wr), .ff_wdata(ff_wdata), .ff_inv_en(ff_inv_en),
      .pwm_out(pwm_out), .period_irq(period_irq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc_irq(output int n, input int lim);
      n = 0;
      do begin @(negedge clk); n++; end while (!period_irq && n < lim);
   endtask

   task automatic cyc_change(output int n, input int lim);
      logic lvl;
      lvl = pwm_out;
      n = 0;
      do begin @(negedge clk); n++; end while (pwm_out == lvl && n < lim);
   endtask

   task automatic write_cmp(input int v);
      cmp_wr = 1'b1; cmp_wdata = 8'(v);
      @(negedge clk);
      cmp_wr = 1'b0;
   endtask

   task automatic setup(input logic [1:0] src, input logic [1:0] per, input int cmpv);
      @(negedge clk);
      run = 1'b0; src_sel = src; period_sel = per; buf_en = 1'b0;
      write_cmp(cmpv);
      run = 1'b1;
   endtask

   task automatic t_reset;
      int n;
      check(pwm_out == 1'b0, "R11 pwm after reset", pwm_out, 0);
      check(period_irq == 1'b0, "R11 irq after reset", period_irq, 0);
      @(negedge clk); run = 1'b1;
      cyc_irq(n, 100);
      cyc_change(n, 100);
      check(n == 64, "R11 zero compare gives no match", n, 64);
   endtask

   task automatic t_width(input logic [1:0] per, input int cmpv, input string tag);
      int n1, n2, pw;
      pw = 1 << (5 + int'(per));
      setup(2'b00, per, cmpv);
      cyc_irq(n1, pw + 8);
      cyc_change(n1, pw + 8);
      check(n1 == cmpv, {tag, " R4 width"}, n1, cmpv);
      cyc_irq(n2, pw + 8);
      check(n1 + n2 == pw, {tag, " R2 period"}, n1 + n2, pw);
      @(negedge clk);
      check(period_irq == 1'b0, {tag, " R2 irq one cycle"}, period_irq, 0);
   endtask

   task automatic t_hold;
      int n;
      setup(2'b00, 2'b00, 16);
      cyc_irq(n, 300);
      check(n == 300, "R3 no irq while held", n, 300);
      period_sel = 2'b01;
      cyc_irq(n, 300);
      check(n <= 64, "R3 counting resumes", n, 64);
   endtask

   task automatic t_unbuf;
      int n;
      setup(2'b00, 2'b01, 16);
      cyc_irq(n, 100);
      write_cmp(40);
      cyc_change(n, 100);
      check(n + 1 == 40, "R5 direct write used this period", n + 1, 40);
   endtask

   task automatic t_buf;
      int n;
      setup(2'b00, 2'b01, 16);
      buf_en = 1'b1;
      cyc_irq(n, 100);
      write_cmp(40);
      cyc_change(n, 100);
      check(n + 1 == 16, "R6 buffered write deferred", n + 1, 16);
      cyc_irq(n, 100);
      cyc_change(n, 100);
      check(n == 40, "R6 buffered value after wrap", n, 40);
      write_cmp(20);
      cyc_irq(n, 100);
      repeat (63) @(negedge clk);
      cmp_wr = 1'b1; cmp_wdata = 8'd50;
      @(negedge clk);
      cmp_wr = 1'b0;
      check(period_irq == 1'b1, "R6 write lands on wrap edge", period_irq, 1);
      cyc_change(n, 100);
      check(n == 20, "R6 coincident write not yet active", n, 20);
      cyc_irq(n, 100);
      cyc_change(n, 100);
      check(n == 50, "R6 coincident write active one wrap later", n, 50);
      buf_en = 1'b0;
   endtask

   task automatic t_ff;
      int n;
      logic lvl;
      @(negedge clk); run = 1'b0;
      ff_wr = 1'b1; ff_wdata = 1'b1;
      @(negedge clk); ff_wr = 1'b0;
      check(pwm_out == 1'b1, "R9 preset", pwm_out, 1);
      ff_wr = 1'b1; ff_wdata = 1'b0;
      @(negedge clk); ff_wr = 1'b0;
      check(pwm_out == 1'b0, "R9 clear", pwm_out, 0);
      setup(2'b00, 2'b01, 16);
      cyc_irq(n, 100);
      repeat (63) @(negedge clk);
      lvl = pwm_out;
      ff_wr = 1'b1; ff_wdata = lvl;
      @(negedge clk); ff_wr = 1'b0;
      check(period_irq == 1'b1, "R9 load on wrap edge", period_irq, 1);
      check(pwm_out == lvl, "R9 load overrides wrap inversion", pwm_out, lvl);
   endtask

   task automatic t_inv;
      int n, irqs;
      logic lvl;
      setup(2'b00, 2'b01, 16);
      ff_inv_en = 1'b0;
      @(negedge clk);
      lvl = pwm_out; irqs = 0;
      for (int i = 0; i < 140; i++) begin
         @(negedge clk);
         if (period_irq) irqs++;
         if (pwm_out != lvl) n++;
      end
      check(irqs >= 2, "R8 irq continues", irqs, 2);
      check(pwm_out == lvl, "R8 level frozen", pwm_out, lvl);
      ff_inv_en = 1'b1;
   endtask

   task automatic t_run;
      int n;
      logic lvl;
      setup(2'b00, 2'b01, 16);
      repeat (30) @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      lvl = pwm_out;
      cyc_irq(n, 200);
      check(n == 200, "R7 no irq while stopped", n, 200);
      check(pwm_out == lvl, "R7 level held while stopped", pwm_out, lvl);
      run = 1'b1;
      cyc_change(n, 100);
      check(n == 16, "R7 restart counts from zero", n, 16);
   endtask

   task automatic t_src;
      int n;
      setup(2'b01, 2'b01, 16);
      cyc_irq(n, 400);
      cyc_irq(n, 400);
      check(n == 256, "R1 quarter-rate period", n, 256);
      setup(2'b10, 2'b01, 16);
      cyc_irq(n, 1200);
      cyc_irq(n, 1200);
      check(n == 1024, "R1 sixteenth-rate period", n, 1024);
   endtask

   task automatic t_ext;
      setup(2'b11, 2'b01, 2);
      ff_wr = 1'b1; ff_wdata = 1'b0;
      @(negedge clk); ff_wr = 1'b0;
      ext_cnt_in = 1'b1;
      repeat (6) @(negedge clk);
      check(pwm_out == 1'b0, "R10 one edge one count", pwm_out, 0);
      repeat (10) @(negedge clk);
      check(pwm_out == 1'b0, "R10 held level adds nothing", pwm_out, 0);
      ext_cnt_in = 1'b0;
      repeat (4) @(negedge clk);
      ext_cnt_in = 1'b1;
      repeat (6) @(negedge clk);
      check(pwm_out == 1'b1, "R10 second edge reaches compare", pwm_out, 1);
      ext_cnt_in = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_width(2'b01, 16, "64");
      t_width(2'b10, 100, "128");
      t_width(2'b11, 200, "256");
      t_hold;
      t_unbuf;
      t_buf;
      t_ff;
      t_inv;
      t_run;
      t_src;
      t_ext;
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule